// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address that a synchronous memory port uses in every clock cycle. It holds the last address used in a register. Each cycle it chooses one of four sources for the address: zero, a new address from outside, the held address plus one, or the held address unchanged. The chosen address appears combinationally in the same cycle as the controls that select it. Because of this, a clear, a load or a step never costs a dead cycle. On the rising edge the chosen address is captured as the new held value.

Three active-low controls select the source, with a fixed priority. Clear is highest, then the address strobe, then the count enable. When all three are inactive, the held address is reused, so a read keeps returning the same location. There is no chip-enable input on purpose. The sequencer must keep counting and loading whatever the selection state of the surrounding memory is. A long burst is produced by one strobe followed by count-enable pulses. Holding count enable high stalls the burst without losing its position.

Top module: `burst_addr_seq`

## Requirements
- R1: While `clr_n` is 0, `addr_now` is 0 whatever `strobe_n`, `step_n` and `ext_addr` are, and `addr_held` is 0 after the next rising edge.
- R2: While `clr_n` is 1 and `strobe_n` is 0, `addr_now` equals `ext_addr`. `step_n` has no effect in that cycle.
- R3: While `clr_n` and `strobe_n` are 1 and `step_n` is 0, `addr_now` equals `addr_held` plus one.
- R4: While `clr_n`, `strobe_n` and `step_n` are all 1, `addr_now` equals `addr_held`, and `addr_held` does not change at the next edge.
- R5: A step from the all-ones address gives address 0.
- R6: The address selected by a clear, a load or a step is presented on `addr_now` in the same cycle as the control, before the edge. No extra cycle is inserted.
- R7: While `rst_n` is 0, `addr_held` is 0. It stays 0 after release until a control changes it.
- R8: After every rising edge outside reset, `addr_held` equals the value `addr_now` had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is expected to be synchronous to clk |
| ext_addr | input | ADDR_W | External address loaded by the strobe |
| strobe_n | input | 1 | Active-low load of ext_addr |
| step_n | input | 1 | Active-low advance by one |
| clr_n | input | 1 | Active-low clear to address 0; highest priority |
| addr_now | output | ADDR_W | Address used in the current cycle |
| addr_held | output | ADDR_W | Registered address carried into the next cycle |

## Verification
The checker tests every cycle that the held register follows the address used before the edge. It also tests the relation each control sets up between the held register and the inputs: zero after a clear, the external value after a load, an increment after a step, and no change when idle. Only the directed scenarios show the priority cases, where controls with lower priority are also asserted and must be ignored. The same applies to the wrap from all ones to zero and to a full burst run of load, steps, stall and clear. In those scenarios the bench predicts each same-cycle address and each held address from the requirements.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Source of the address used in a cycle, listed from lowest to highest priority.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_STEP = 2'd1,
    SRC_LOAD = 2'd2,
    SRC_ZERO = 2'd3
  } addr_src_e;

endpackage

// File: rtl/burst_addr_prio.sv
module burst_addr_prio
  import burst_addr_pkg::*;
(
  input  logic      strobe_n,
  input  logic      step_n,
  input  logic      clr_n,
  output addr_src_e src
);

  // Priority order: clear, then load, then step, otherwise hold.
  always_comb begin
    if (!clr_n) begin
      src = SRC_ZERO;
    end else if (!strobe_n) begin
      src = SRC_LOAD;
    end else if (!step_n) begin
      src = SRC_STEP;
    end else begin
      src = SRC_HOLD;
    end
  end

endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  addr_src_e         src,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);

  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ZERO = '0;

  logic [ADDR_W-1:0] inc_addr;

  // The sum is truncated to the address width, so all ones steps to zero.
  always_comb begin
    inc_addr = cur_addr + ONE;
  end

  always_comb begin
    unique case (src)
      SRC_ZERO: nxt_addr = ZERO;
      SRC_LOAD: nxt_addr = ext_addr;
      SRC_STEP: nxt_addr = inc_addr;
      default:  nxt_addr = cur_addr;
    endcase
  end

endmodule

// File: rtl/burst_addr_hold.sv
module burst_addr_hold #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] d_addr,
  output logic [ADDR_W-1:0] q_addr
);

  logic [ADDR_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_addr;
    if (load_en) begin
      q_nxt = d_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr <= '0;
    end else begin
      q_addr <= q_nxt;
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic              clr_n,
  output logic [ADDR_W-1:0] addr_now,
  output logic [ADDR_W-1:0] addr_held
);

  addr_src_e         src;
  logic              upd_en;
  logic [ADDR_W-1:0] nxt_addr;

  burst_addr_prio u_prio (
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .clr_n    (clr_n),
    .src      (src)
  );

  burst_addr_next #(.ADDR_W(ADDR_W)) u_next (
    .src      (src),
    .ext_addr (ext_addr),
    .cur_addr (addr_held),
    .nxt_addr (nxt_addr)
  );

  // The register is written only when a control is active; an idle cycle keeps its value.
  always_comb begin
    upd_en = (src != SRC_HOLD);
  end

  burst_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (upd_en),
    .d_addr  (nxt_addr),
    .q_addr  (addr_held)
  );

  always_comb begin
    addr_now = nxt_addr;
  end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              strobe_n,
  input logic              step_n,
  input logic              clr_n,
  input logic [ADDR_W-1:0] addr_now,
  input logic [ADDR_W-1:0] addr_held
);

  logic              live_q;
  logic [ADDR_W-1:0] held_plus;

  // Set one edge after reset release, so $past only sees cycles after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
    end
  end

  always_comb begin
    held_plus = addr_held + ADDR_W'(1);
  end

  always_comb begin
    if (!rst_n) begin
      AST_RESET_HELD_ZERO: assert (addr_held == '0); // R7
    end
  end

  AST_CLEAR_NOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> addr_now == '0); // R1

  AST_CLEAR_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> addr_held == '0); // R1

  AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !strobe_n) |=> addr_held == $past(ext_addr)); // R2

  AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && strobe_n && !step_n) |-> addr_now == held_plus); // R3

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && strobe_n && step_n) |=> $stable(addr_held)); // R4

  AST_HELD_TRACKS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> addr_held == $past(addr_now)); // R8

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_addr  (ext_addr),
  .strobe_n  (strobe_n),
  .step_n    (step_n),
  .clr_n     (clr_n),
  .addr_now  (addr_now),
  .addr_held (addr_held)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int unsigned AW       = 16;
  localparam time         CLK_PER  = 10ns;
  localparam int unsigned WD_LIMIT = 20000;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          strobe_n;
  logic          step_n;
  logic          clr_n;
  logic [AW-1:0] addr_now;
  logic [AW-1:0] addr_held;

  int checks;
  int failures;
  bit done;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .strobe_n  (strobe_n),
    .step_n    (step_n),
    .clr_n     (clr_n),
    .addr_now  (addr_now),
    .addr_held (addr_held)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PER / 2) clk = ~clk;
  end

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive on the falling edge, check the same-cycle address,
  // then check the held address just after the rising edge.
  task automatic cycle(input logic c, input logic s, input logic a,
                       input logic [AW-1:0] ext, input logic [AW-1:0] exp, input string req);
    @(negedge clk);
    clr_n    = c;
    strobe_n = s;
    step_n   = a;
    ext_addr = ext;
    #1;
    check({req, " now R6"}, addr_now, exp);
    @(posedge clk);
    #1;
    check({req, " held R8"}, addr_held, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n    = 1'b0;
    clr_n    = 1'b1;
    strobe_n = 1'b1;
    step_n   = 1'b1;
    ext_addr = 16'h5A5A;
    #1;
    check("R7 held in reset", addr_held, 16'h0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 now after reset", addr_now, 16'h0000);
    cycle(1'b1, 1'b1, 1'b1, 16'h5A5A, 16'h0000, "R7 idle after reset");
  endtask

  task automatic t_load;
    cycle(1'b1, 1'b0, 1'b1, 16'h1234, 16'h1234, "R2 load");
    cycle(1'b1, 1'b0, 1'b0, 16'h0100, 16'h0100, "R2 load ignores step");
  endtask

  task automatic t_step;
    cycle(1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0101, "R3 step");
    cycle(1'b1, 1'b1, 1'b0, 16'h0000, 16'h0102, "R3 step again");
  endtask

  task automatic t_hold;
    cycle(1'b1, 1'b1, 1'b1, 16'h7777, 16'h0102, "R4 hold");
    cycle(1'b1, 1'b1, 1'b1, 16'h8888, 16'h0102, "R4 hold again");
  endtask

  task automatic t_clear;
    cycle(1'b0, 1'b0, 1'b0, 16'h4321, 16'h0000, "R1 clear over load and step");
    cycle(1'b1, 1'b1, 1'b0, 16'h4321, 16'h0001, "R1 step after clear");
    cycle(1'b0, 1'b1, 1'b1, 16'h4321, 16'h0000, "R1 clear alone");
  endtask

  task automatic t_wrap;
    cycle(1'b1, 1'b0, 1'b1, 16'hFFFE, 16'hFFFE, "R5 load near top");
    cycle(1'b1, 1'b1, 1'b0, 16'h0000, 16'hFFFF, "R5 step to top");
    cycle(1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, "R5 wrap");
  endtask

  task automatic t_burst;
    logic [AW-1:0] e;
    cycle(1'b1, 1'b0, 1'b1, 16'h2000, 16'h2000, "R6 burst load");
    e = 16'h2000;
    for (int i = 0; i < 6; i++) begin
      if (i == 3) begin
        cycle(1'b1, 1'b1, 1'b1, 16'h0000, e, "R4 burst stall");
      end else begin
        e = e + 16'h0001;
        cycle(1'b1, 1'b1, 1'b0, 16'h0000, e, "R3 burst step");
      end
    end
    cycle(1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, "R6 clear mid burst");
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    clr_n    = 1'b1;
    strobe_n = 1'b1;
    step_n   = 1'b1;
    ext_addr = '0;
    t_reset();
    t_load();
    t_step();
    t_hold();
    t_clear();
    t_wrap();
    t_burst();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule